// File: doc/BRIEF.md
# UART Line Status Tracker

This block keeps the line status flags of a UART with 16-entry transmit and receive buffers. On the transmit side it reports whether the holding stage is empty and whether the whole transmitter is idle. It does this from the transmit FIFO occupancy, the shift register busy state and the holding register write and transfer strobes. On the receive side it owns the receive FIFO. Characters arrive from the deserializer with parity, framing and break tags, and the host takes them out. The block also watches the raw RX line for a break.

The block works in two modes. With `fifo_mode` high, the receive store holds `DEPTH` characters and the transmit empty flag follows the transmit FIFO count. With `fifo_mode` low, the receive store holds one character and the transmit empty flag follows a single holding register. `fifo_mode` is expected to change only while both paths are empty.

Both character streams use valid/ready. The receiver push completes on a clock edge where `rx_valid` and `rx_ready` are both high. The receiver must hold `rx_valid` and its data until that happens. `rx_ready` drops while the store is full, and also in the cycle where a break character is inserted. The host pop completes on an edge where `pop_valid` and `pop_ready` are both high. The `pop_*` outputs always show the oldest stored character.

Top module: `uart_line_status`

## Requirements
- R1: With `fifo_mode` low, `thr_empty` is 0 in the same cycle that `thr_wr` is high. It stays 0 until a `thr_xfer` strobe without `thr_wr`, and it is 1 from the cycle after that strobe.
- R2: With `fifo_mode` high, `thr_empty` is 1 exactly when `tx_count` is 0.
- R3: `tx_empty` is 1 only when `thr_empty` is 1 and `tsr_busy` is 0.
- R4: `brk_flag` becomes 1 in the cycle after the `FRAME_CYCLES`-th consecutive clock edge that samples `rx_line` low. It is still 0 one cycle earlier.
- R5: A high `lsr_rd` clears `brk_flag` at the next edge, unless a new break is detected at that edge. A line that stays low does not set the flag again.
- R6: Each unbroken low stretch of `rx_line` that reaches `FRAME_CYCLES` stores exactly one character in the receive FIFO: data 0 with only the break tag set, provided there is room. Another break character can be stored only after `rx_line` has been high.
- R7: `rx_fifo_err` is 1 while at least one stored character has its parity, framing or break tag set. It is 0 once no stored character carries a tag.
- R8: If a tagged character is pushed in the same cycle that a tagged character is popped, `rx_fifo_err` stays 1. It falls only when the last tagged character leaves.
- R9: Characters leave the receive FIFO in arrival order, with data and tags intact. `rx_ready` is 0 when the FIFO holds `DEPTH` characters with `fifo_mode` high, or one character with `fifo_mode` low.
- R10: After reset `brk_flag`, `rx_fifo_err` and `pop_valid` are 0. `thr_empty` and `tx_empty` are 1 while the transmit side is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single-register mode |
| tx_count | input | $clog2(DEPTH)+1 | Transmit FIFO occupancy |
| tsr_busy | input | 1 | Transmit shift register holds a character |
| thr_wr | input | 1 | Host writes the holding register (single-register mode) |
| thr_xfer | input | 1 | Holding byte moves into the shift register |
| rx_line | input | 1 | Synchronised RX line level |
| rx_valid | input | 1 | Receiver offers a character |
| rx_ready | output | 1 | Receive FIFO accepts the offered character |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error tag |
| rx_ferr | input | 1 | Framing error tag |
| rx_brk | input | 1 | Break tag |
| pop_valid | output | 1 | Receive FIFO not empty |
| pop_ready | input | 1 | Host reads the receive FIFO |
| pop_data | output | 8 | Oldest character |
| pop_perr | output | 1 | Its parity tag |
| pop_ferr | output | 1 | Its framing tag |
| pop_brk | output | 1 | Its break tag |
| lsr_rd | input | 1 | Host reads the status register |
| brk_flag | output | 1 | Break seen since last status read |
| thr_empty | output | 1 | Holding stage empty |
| tx_empty | output | 1 | Holding stage and shift register empty |
| rx_fifo_err | output | 1 | Some stored character carries a tag |

## Verification
The bench holds `rx_line` low well past one frame. A detector that did not saturate would queue extra break characters, and a flag set from the level instead of the crossing would come back after a status read. It pushes a tagged character in the same cycle it pops another tagged one. A counter that let the decrement win would drop `rx_fifo_err` while a tagged character is still stored. It also probes `thr_empty` in the very cycle of a holding write and in the cycle of the transfer strobe, so a flag that is one cycle early or late is seen. Finally it fills the store to capacity in both modes, so a wrong depth or a wrong order shows up as a refused push or a miscompare.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_char_t;

  function automatic logic char_tagged(rx_char_t c);
    return c.perr | c.ferr | c.brk;
  endfunction
endpackage

// File: rtl/lsr_rx_fifo.sv
module lsr_rx_fifo
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cap_one,
  input  logic     in_valid,
  output logic     in_ready,
  input  rx_char_t in_char,
  output logic     out_valid,
  input  logic     out_ready,
  output rx_char_t out_char,
  output logic     err_any
);
  rx_char_t        mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CW-1:0]   fill;
  logic [CW-1:0]   tag_cnt;
  logic            do_push, do_pop, full;

  assign full      = cap_one ? (fill != '0) : (fill == CW'(DEPTH));
  assign in_ready  = !full;
  assign out_valid = (fill != '0);
  assign do_push   = in_valid && !full;
  assign do_pop    = out_valid && out_ready;
  assign out_char  = mem[rptr];
  assign err_any   = (tag_cnt != '0);

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wptr] <= in_char;
        wptr      <= bump(wptr);
      end
      if (do_pop) rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // Count of stored characters that carry any tag.
  logic tin, tout;
  assign tin  = do_push && char_tagged(in_char);
  assign tout = do_pop  && char_tagged(out_char);

  always_ff @(posedge clk) begin
    if (!rst_n) tag_cnt <= '0;
    else begin
      case ({tin, tout})
        2'b10:   tag_cnt <= tag_cnt + 1'b1;
        2'b01:   tag_cnt <= tag_cnt - 1'b1;
        default: tag_cnt <= tag_cnt;
      endcase
    end
  end
endmodule

// File: rtl/lsr_break_det.sv
module lsr_break_det #(
  parameter int FRAME_CYCLES = 160,
  localparam int BW = $clog2(FRAME_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  output logic hit
);
  logic [BW-1:0] low_cnt;

  // Saturating run length of low samples: the crossing happens once per stretch.
  always_ff @(posedge clk) begin
    if (!rst_n)                        low_cnt <= '0;
    else if (rx_line)                  low_cnt <= '0;
    else if (low_cnt != BW'(FRAME_CYCLES)) low_cnt <= low_cnt + 1'b1;
  end

  assign hit = !rx_line && (low_cnt == BW'(FRAME_CYCLES - 1));
endmodule

// File: rtl/lsr_tx_status.sv
module lsr_tx_status #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic [CW-1:0] tx_count,
  input  logic          tsr_busy,
  input  logic          thr_wr,
  input  logic          thr_xfer,
  output logic          thr_empty,
  output logic          tx_empty
);
  logic hold_full;

  // A write in the same cycle as a transfer leaves a fresh byte behind.
  always_ff @(posedge clk) begin
    if (!rst_n)        hold_full <= 1'b0;
    else if (thr_wr)   hold_full <= 1'b1;
    else if (thr_xfer) hold_full <= 1'b0;
  end

  always_comb begin
    if (fifo_mode) thr_empty = (tx_count == '0);
    else           thr_empty = !hold_full && !thr_wr;
    tx_empty = thr_empty && !tsr_busy;
  end
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FRAME_CYCLES = 160,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic [CW-1:0] tx_count,
  input  logic          tsr_busy,
  input  logic          thr_wr,
  input  logic          thr_xfer,
  input  logic          rx_line,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [7:0]    pop_data,
  output logic          pop_perr,
  output logic          pop_ferr,
  output logic          pop_brk,
  input  logic          lsr_rd,
  output logic          brk_flag,
  output logic          thr_empty,
  output logic          tx_empty,
  output logic          rx_fifo_err
);
  logic     brk_hit, fifo_in_ready, fifo_in_valid;
  rx_char_t fifo_in, fifo_out;

  lsr_tx_status #(.CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .tx_count(tx_count),
    .tsr_busy(tsr_busy), .thr_wr(thr_wr), .thr_xfer(thr_xfer),
    .thr_empty(thr_empty), .tx_empty(tx_empty)
  );

  lsr_break_det #(.FRAME_CYCLES(FRAME_CYCLES)) u_brk (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .hit(brk_hit)
  );

  // Break insertion owns the write port for its one cycle.
  always_comb begin
    if (brk_hit) begin
      fifo_in      = '0;
      fifo_in.brk  = 1'b1;
    end else begin
      fifo_in.data = rx_data;
      fifo_in.perr = rx_perr;
      fifo_in.ferr = rx_ferr;
      fifo_in.brk  = rx_brk;
    end
  end
  assign fifo_in_valid = brk_hit || rx_valid;
  assign rx_ready      = fifo_in_ready && !brk_hit;

  lsr_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .cap_one(!fifo_mode),
    .in_valid(fifo_in_valid), .in_ready(fifo_in_ready), .in_char(fifo_in),
    .out_valid(pop_valid), .out_ready(pop_ready), .out_char(fifo_out),
    .err_any(rx_fifo_err)
  );

  assign pop_data = fifo_out.data;
  assign pop_perr = fifo_out.perr;
  assign pop_ferr = fifo_out.ferr;
  assign pop_brk  = fifo_out.brk;

  always_ff @(posedge clk) begin
    if (!rst_n)       brk_flag <= 1'b0;
    else if (brk_hit) brk_flag <= 1'b1;
    else if (lsr_rd)  brk_flag <= 1'b0;
  end
endmodule

// File: rtl/uart_line_status_chk.sv
module uart_line_status_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_mode,
  input logic [CW-1:0] tx_count,
  input logic          tsr_busy,
  input logic          thr_wr,
  input logic          thr_xfer,
  input logic          rx_line,
  input logic          lsr_rd,
  input logic          rx_ready,
  input logic          pop_valid,
  input logic          brk_flag,
  input logic          thr_empty,
  input logic          tx_empty,
  input logic          rx_fifo_err
);
  p_thre_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && thr_wr) |-> !thr_empty);

  p_thre_after_xfer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && thr_xfer && !thr_wr) |=> (fifo_mode || thr_wr || thr_empty));

  p_thre_fifo_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode |-> (thr_empty == (tx_count == '0)));

  p_temt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (thr_empty && !tsr_busy));

  p_brk_rise_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> !$past(rx_line));

  p_brk_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && rx_line) |=> !brk_flag);

  p_err_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_valid |-> !rx_fifo_err);

  p_single_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && pop_valid) |-> !rx_ready);
endmodule

bind uart_line_status uart_line_status_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .tx_count(tx_count),
  .tsr_busy(tsr_busy), .thr_wr(thr_wr), .thr_xfer(thr_xfer), .rx_line(rx_line),
  .lsr_rd(lsr_rd), .rx_ready(rx_ready), .pop_valid(pop_valid),
  .brk_flag(brk_flag), .thr_empty(thr_empty), .tx_empty(tx_empty),
  .rx_fifo_err(rx_fifo_err)
);

// File: tb/tb_uart_line_status.sv
module tb_uart_line_status;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int FRAME = 24;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b1;
  logic [CW-1:0] tx_count = '0;
  logic tsr_busy = 1'b0, thr_wr = 1'b0, thr_xfer = 1'b0;
  logic rx_line = 1'b1, rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic pop_ready = 1'b0, lsr_rd = 1'b0;
  logic rx_ready, pop_valid, pop_perr, pop_ferr, pop_brk;
  logic [7:0] pop_data;
  logic brk_flag, thr_empty, tx_empty, rx_fifo_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [10:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_line_status #(.DEPTH(DEPTH), .FRAME_CYCLES(FRAME)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .tx_count(tx_count),
    .tsr_busy(tsr_busy), .thr_wr(thr_wr), .thr_xfer(thr_xfer), .rx_line(rx_line),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
    .pop_perr(pop_perr), .pop_ferr(pop_ferr), .pop_brk(pop_brk),
    .lsr_rd(lsr_rd), .brk_flag(brk_flag), .thr_empty(thr_empty),
    .tx_empty(tx_empty), .rx_fifo_err(rx_fifo_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Monitor: a pop handshake is seen mid low phase and completes at the next edge.
  always @(negedge clk) begin
    #1;
    if (rst_n && pop_valid && pop_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected pop", {21'd0, pop_data, pop_perr, pop_ferr, pop_brk}, 32'd0);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk({pop_data, pop_perr, pop_ferr, pop_brk} == e, "R9 order/content",
            {21'd0, pop_data, pop_perr, pop_ferr, pop_brk}, {21'd0, e});
      end
    end
  end

  // Driver: offer one character; record it as expected only if accepted.
  task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b, output bit took);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    #1;
    took = rx_ready;
    if (took) exp_q.push_back({d, p, f, b});
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    pop_ready = 1'b1;
    for (int i = 0; i < 4 * DEPTH && pop_valid; i++) @(negedge clk);
    pop_ready = 1'b0;
    #2;
    chk(!pop_valid, "R9 drained", {31'd0, pop_valid}, 0);
    chk(exp_q.size() == 0, "R9 all expected seen", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    bit took;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(brk_flag == 0, "R10 brk_flag", brk_flag, 0);
    chk(rx_fifo_err == 0, "R10 rx_fifo_err", rx_fifo_err, 0);
    chk(pop_valid == 0, "R10 pop_valid", pop_valid, 0);
    chk(thr_empty == 1, "R10 thr_empty", thr_empty, 1);
    chk(tx_empty == 1, "R10 tx_empty", tx_empty, 1);

    // R2 / R3 FIFO mode transmit flags
    @(negedge clk); tx_count = 3; #1;
    chk(thr_empty == 0, "R2 count 3", thr_empty, 0);
    chk(tx_empty == 0, "R3 count 3", tx_empty, 0);
    @(negedge clk); tx_count = 0; tsr_busy = 1; #1;
    chk(thr_empty == 1, "R2 count 0", thr_empty, 1);
    chk(tx_empty == 0, "R3 shifter busy", tx_empty, 0);
    @(negedge clk); tsr_busy = 0; #1;
    chk(tx_empty == 1, "R3 idle", tx_empty, 1);

    // R1 single-register mode
    @(negedge clk); fifo_mode = 0; tx_count = 1; thr_wr = 1; #1;
    chk(thr_empty == 0, "R1 clear in write cycle", thr_empty, 0);
    @(negedge clk); thr_wr = 0; #1;
    chk(thr_empty == 0, "R1 held", thr_empty, 0);
    @(negedge clk); thr_xfer = 1; #1;
    chk(thr_empty == 0, "R1 xfer cycle", thr_empty, 0);
    @(negedge clk); thr_xfer = 0; tsr_busy = 1; #1;
    chk(thr_empty == 1, "R1 set after xfer", thr_empty, 1);
    chk(tx_empty == 0, "R3 shifter still busy", tx_empty, 0);
    @(negedge clk); tsr_busy = 0; #1;
    chk(tx_empty == 1, "R3 idle single mode", tx_empty, 1);

    // R9 single-register capacity
    push(8'h5A, 0, 0, 0, took);
    chk(took, "R9 first accepted", took, 1);
    push(8'h66, 0, 0, 0, took);
    chk(!took, "R9 single cap refuses", took, 0);
    drain();

    // R9 / R7 FIFO mode fill
    @(negedge clk); fifo_mode = 1; tx_count = 0;
    for (int i = 0; i < DEPTH; i++) begin
      push(8'(i * 7 + 1), (i == 3), (i == 9), 1'b0, took);
      chk(took, "R9 fill accepted", took, 1);
    end
    push(8'hEE, 0, 0, 0, took);
    chk(!took, "R9 full refuses", took, 0);
    chk(rx_fifo_err == 1, "R7 tags stored", rx_fifo_err, 1);
    drain();
    chk(rx_fifo_err == 0, "R7 cleared when empty", rx_fifo_err, 0);

    // R8 simultaneous tagged push and pop
    push(8'h11, 1, 0, 0, took);
    @(negedge clk);
    rx_valid = 1; rx_data = 8'h22; rx_perr = 0; rx_ferr = 1; rx_brk = 0; pop_ready = 1;
    #1;
    if (rx_ready) exp_q.push_back({8'h22, 1'b0, 1'b1, 1'b0});
    @(negedge clk); rx_valid = 0; pop_ready = 0; #1;
    chk(rx_fifo_err == 1, "R8 flag kept", rx_fifo_err, 1);
    chk(pop_valid == 1, "R8 one left", pop_valid, 1);
    drain();
    chk(rx_fifo_err == 0, "R8 clear after last", rx_fifo_err, 0);

    // R4 break detection timing
    @(negedge clk); rx_line = 0;
    repeat (FRAME - 1) @(posedge clk);
    @(negedge clk); #1;
    chk(brk_flag == 0, "R4 not before frame", brk_flag, 0);
    @(negedge clk); #1;
    chk(brk_flag == 1, "R4 set at frame", brk_flag, 1);
    exp_q.push_back({8'h00, 1'b0, 1'b0, 1'b1});
    chk(pop_valid == 1, "R6 break char stored", pop_valid, 1);
    chk(rx_fifo_err == 1, "R7 break tag", rx_fifo_err, 1);
    repeat (2 * FRAME) @(negedge clk);
    // R5 status read clears, no re-set while still low
    @(negedge clk); lsr_rd = 1;
    @(negedge clk); lsr_rd = 0; #1;
    chk(brk_flag == 0, "R5 cleared by read", brk_flag, 0);
    repeat (2 * FRAME) @(negedge clk);
    #1;
    chk(brk_flag == 0, "R5 no re-set while low", brk_flag, 0);
    drain();  // R6: exactly one break entry
    chk(rx_fifo_err == 0, "R7 clear after break pop", rx_fifo_err, 0);

    // R6 new break after mark
    @(negedge clk); rx_line = 1;
    repeat (3) @(negedge clk);
    rx_line = 0;
    repeat (FRAME + 2) @(negedge clk);
    #1;
    chk(brk_flag == 1, "R6 second break flag", brk_flag, 1);
    chk(pop_valid == 1, "R6 second break char", pop_valid, 1);
    exp_q.push_back({8'h00, 1'b0, 1'b0, 1'b1});
    @(negedge clk); rx_line = 1;
    drain();

    finish_run();
  end
endmodule